// File: doc/BRIEF.md
# Cluster Control Register Block

This block is the shared control register file of a small multicore cluster. Up to eight virtual processors (VPs) reach it over a plain register bus. Each access carries an address, a write strobe, 64-bit write data and the index of the VP that issues it. Read data comes back one cycle later from a register.

The block keeps its own relocatable window base and exports it, shifted right by four, to every VP. It also keeps base-plus-enable registers for an interrupt-controller window and a power-controller window, and drives the decoded address and enable of each onto dedicated outputs.

Each VP owns a small bank with a selector and a reset-base register. The core-local view acts on the requester's own bank. The core-other view acts on the bank that the requester's selector points to. A selector write that names a VP which does not exist is dropped. Each VP's boot exception vector is exported continuously from its bank.

Top module: `clu_ctrl_regs`

## Requirements
- R1: After reset every selector is 0, every reset-base register holds 0xBFC00000 (so every vector output is 0xFFFFFFFF_BFC00000), both sub-window registers are 0 with their enables low, and the self-base register holds SELF_BASE_INIT masked to bits [47:15].
- R2: `bus_rdata` presents, one clock after the edge that samples the address, the value of the addressed register as it was before any write on that same edge; a write takes effect on the edge where `bus_we` is high.
- R3: Address bits [15:13] = 1 select the core-local view (base 0x2000), which acts on the bank of VP `req_vp`.
- R4: Address bits [15:13] = 2 select the core-other view (base 0x4000), which acts on the bank named by the selector of VP `req_vp`.
- R5: A selector write (core offset 0x18, either view) takes wdata[15:0]; it is stored only when that value is below NVP, otherwise the old selector stays. A selector reads back zero-extended.
- R6: A reset-base write (core offset 0x20, either view) keeps wdata[31:12] and clears every other bit; the VP's vector output, one cycle later, is that value sign-extended from bit 31.
- R7: Core offset 0x10 reads NVP-1 in both core views; global offset 0x00 reads 0.
- R8: Global offset 0x18 is the interrupt-controller register (address field [47:17], enable bit 0) and global offset 0x20 the power-controller register (address field [47:15], enable bit 0); stored bits outside these fields read 0, `intc_base`/`pwr_base` carry the address field and `intc_en`/`pwr_en` the enable bit.
- R9: Global offset 0x28 reads `intc_present` and 0x30 reads `pwr_present` in bit 0; a write to a sub-window register while its present input is low leaves it unchanged.
- R10: Global offset 0x10 reads the REV parameter (default 0x800); global offset 0x38 reads only bit 20 set.
- R11: Global offset 0x08 stores wdata[47:15]; `self_base` carries the stored value and `cpu_gbase` carries it shifted right by 4.
- R12: Any other address reads 0, and a write to it changes no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vp | input | VPW | Index of the requesting VP (below NVP) |
| bus_addr | input | 16 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| intc_present | input | 1 | Interrupt-controller window exists |
| pwr_present | input | 1 | Power-controller window exists |
| self_base | output | 64 | Own window base |
| cpu_gbase | output | 64 | Own window base shifted right by 4, for every VP |
| intc_base | output | 64 | Interrupt-controller window address |
| intc_en | output | 1 | Interrupt-controller window enable |
| pwr_base | output | 64 | Power-controller window address |
| pwr_en | output | 1 | Power-controller window enable |
| vp_vector | output | NVP*64 | Per-VP boot exception vector, VP i in bits [64i+63:64i] |

## Verification
The bench builds the block with NVP = 3, so the selector is two bits wide and the value 3 fits the field yet must be rejected; this separates the range check from plain truncation. Masked selector values such as 0x10002 show that only bits [15:0] are compared. With three VPs, a core-other access can reach a bank other than the requester's own, and the alias chains through selectors that later change. The present inputs are toggled at run time, so both the read and the ignored write for an absent sub-window are covered.

// File: rtl/clu_ctrl_pkg.sv
package clu_ctrl_pkg;
  localparam int DW = 64;
  localparam int AW = 16;

  // block select in address bits [15:13]
  localparam logic [2:0] BLK_GLB = 3'd0;
  localparam logic [2:0] BLK_LOC = 3'd1;
  localparam logic [2:0] BLK_OTH = 3'd2;

  // global block offsets
  localparam logic [12:0] G_CFG     = 13'h000;
  localparam logic [12:0] G_SELF    = 13'h008;
  localparam logic [12:0] G_REV     = 13'h010;
  localparam logic [12:0] G_INTC    = 13'h018;
  localparam logic [12:0] G_PWR     = 13'h020;
  localparam logic [12:0] G_INTC_ST = 13'h028;
  localparam logic [12:0] G_PWR_ST  = 13'h030;
  localparam logic [12:0] G_L2      = 13'h038;

  // core block offsets
  localparam logic [12:0] C_CFG = 13'h010;
  localparam logic [12:0] C_SEL = 13'h018;
  localparam logic [12:0] C_RB  = 13'h020;

  localparam logic [DW-1:0] SELF_MASK = 64'h0000_FFFF_FFFF_8000;
  localparam logic [DW-1:0] INTC_MASK = 64'h0000_FFFF_FFFE_0000;
  localparam logic [DW-1:0] PWR_MASK  = 64'h0000_FFFF_FFFF_8000;
  localparam logic [DW-1:0] RB_MASK   = 64'h0000_0000_FFFF_F000;
  localparam logic [DW-1:0] RB_INIT   = 64'h0000_0000_BFC0_0000;
  localparam logic [DW-1:0] L2_BYPASS = 64'h0000_0000_0010_0000;
endpackage

// File: rtl/clu_subwin.sv
module clu_subwin
  import clu_ctrl_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_MASK = 64'h0000_FFFF_FFFF_8000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          present,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] base,
  output logic          en
);
  localparam logic [DW-1:0] KEEP = ADDR_MASK | 64'd1;

  always_ff @(posedge clk) begin
    if (rst) raw <= '0;
    else if (we && present) raw <= wdata & KEEP;
  end

  assign base = raw & ADDR_MASK;
  assign en   = raw[0];

  AST_ABSENT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (we && !present) |=> $stable(raw)); // R9
  AST_WIN_STORE: assert property (@(posedge clk) disable iff (rst)
    (we && present) |=> (raw == ($past(wdata) & KEEP))); // R8
endmodule

// File: rtl/clu_vp_bank.sv
module clu_vp_bank
  import clu_ctrl_pkg::*;
#(
  parameter int NVP = 4,
  parameter int VPW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel_we,
  input  logic [15:0]    sel_wdata,
  input  logic           rb_we,
  input  logic [DW-1:0]  rb_wdata,
  output logic [VPW-1:0] sel,
  output logic [DW-1:0]  rbase,
  output logic [DW-1:0]  vector
);
  logic sel_ok;
  assign sel_ok = (sel_wdata < 16'(NVP));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= '0;
      rbase <= RB_INIT & RB_MASK;
    end else begin
      if (sel_we && sel_ok) sel <= sel_wdata[VPW-1:0];
      if (rb_we) rbase <= rb_wdata & RB_MASK;
    end
  end

  assign vector = {{32{rbase[31]}}, rbase[31:0]};

  AST_SEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, sel} < (VPW+1)'(NVP))); // R5
  AST_SEL_REJECT: assert property (@(posedge clk) disable iff (rst)
    (sel_we && (sel_wdata >= 16'(NVP))) |=> $stable(sel)); // R5
  AST_RB_STORE: assert property (@(posedge clk) disable iff (rst)
    rb_we |=> (rbase == ($past(rb_wdata) & RB_MASK))); // R6
endmodule

// File: rtl/clu_ctrl_regs.sv
module clu_ctrl_regs
  import clu_ctrl_pkg::*;
#(
  parameter int          NVP            = 4,
  parameter logic [63:0] REV            = 64'h800,
  parameter logic [63:0] SELF_BASE_INIT = 64'h0000_0000_1FBF_8000,
  localparam int         VPW            = (NVP > 1) ? $clog2(NVP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPW-1:0]    req_vp,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              intc_present,
  input  logic              pwr_present,
  output logic [DW-1:0]     self_base,
  output logic [DW-1:0]     cpu_gbase,
  output logic [DW-1:0]     intc_base,
  output logic              intc_en,
  output logic [DW-1:0]     pwr_base,
  output logic              pwr_en,
  output logic [NVP*DW-1:0] vp_vector
);
  logic [2:0]  blk;
  logic [12:0] ofs;
  logic        in_glb, in_loc, in_oth;
  assign blk    = bus_addr[15:13];
  assign ofs    = bus_addr[12:0];
  assign in_glb = (blk == BLK_GLB);
  assign in_loc = (blk == BLK_LOC);
  assign in_oth = (blk == BLK_OTH);

  logic [VPW-1:0] sel_v [NVP];
  logic [DW-1:0]  rb_v  [NVP];
  logic [VPW-1:0] tgt;

  // bank reached through the core-other view
  always_comb begin
    tgt = '0;
    for (int i = 0; i < NVP; i++)
      if (req_vp == VPW'(i)) tgt = sel_v[i];
  end

  logic [VPW-1:0] core_vp;
  assign core_vp = in_loc ? req_vp : tgt;

  generate
    for (genvar i = 0; i < NVP; i++) begin : g_bank
      logic hit;
      assign hit = (in_loc || in_oth) && (core_vp == VPW'(i));
      clu_vp_bank #(.NVP(NVP), .VPW(VPW)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (bus_we && hit && (ofs == C_SEL)),
        .sel_wdata (bus_wdata[15:0]),
        .rb_we     (bus_we && hit && (ofs == C_RB)),
        .rb_wdata  (bus_wdata),
        .sel       (sel_v[i]),
        .rbase     (rb_v[i]),
        .vector    (vp_vector[i*DW +: DW])
      );
    end
  endgenerate

  logic [DW-1:0] intc_raw, pwr_raw;

  clu_subwin #(.ADDR_MASK(INTC_MASK)) u_intc (
    .clk (clk), .rst (rst), .present (intc_present),
    .we (bus_we && in_glb && (ofs == G_INTC)), .wdata (bus_wdata),
    .raw (intc_raw), .base (intc_base), .en (intc_en)
  );

  clu_subwin #(.ADDR_MASK(PWR_MASK)) u_pwr (
    .clk (clk), .rst (rst), .present (pwr_present),
    .we (bus_we && in_glb && (ofs == G_PWR)), .wdata (bus_wdata),
    .raw (pwr_raw), .base (pwr_base), .en (pwr_en)
  );

  logic [DW-1:0] self_q;
  always_ff @(posedge clk) begin
    if (rst) self_q <= SELF_BASE_INIT & SELF_MASK;
    else if (bus_we && in_glb && (ofs == G_SELF)) self_q <= bus_wdata & SELF_MASK;
  end
  assign self_base = self_q;
  assign cpu_gbase = self_q >> 4;

  // read path
  logic [VPW-1:0] rd_sel;
  logic [DW-1:0]  rd_rb, rd_n;
  logic           mapped;

  always_comb begin
    rd_sel = '0;
    rd_rb  = '0;
    for (int i = 0; i < NVP; i++)
      if (core_vp == VPW'(i)) begin
        rd_sel = sel_v[i];
        rd_rb  = rb_v[i];
      end
  end

  always_comb begin
    rd_n   = '0;
    mapped = 1'b0;
    if (in_glb) begin
      mapped = 1'b1;
      case (ofs)
        G_CFG:     rd_n = '0;
        G_SELF:    rd_n = self_q;
        G_REV:     rd_n = REV;
        G_INTC:    rd_n = intc_raw;
        G_PWR:     rd_n = pwr_raw;
        G_INTC_ST: rd_n = {63'd0, intc_present};
        G_PWR_ST:  rd_n = {63'd0, pwr_present};
        G_L2:      rd_n = L2_BYPASS;
        default:   mapped = 1'b0;
      endcase
    end else if (in_loc || in_oth) begin
      mapped = 1'b1;
      case (ofs)
        C_CFG:   rd_n = 64'(NVP - 1);
        C_SEL:   rd_n = 64'(rd_sel);
        C_RB:    rd_n = rd_rb;
        default: mapped = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_n;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mapped |=> (bus_rdata == '0)); // R12
  AST_CORE_CFG: assert property (@(posedge clk) disable iff (rst)
    ((in_loc || in_oth) && (ofs == C_CFG)) |=> (bus_rdata == 64'(NVP - 1))); // R7
  AST_SELF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && in_glb && (ofs == G_SELF)) |=> $stable(self_base)); // R11
endmodule

// File: tb/clu_ctrl_regs_test.sv
module clu_ctrl_regs_test;
  localparam int NVP = 3;
  localparam int VPW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [VPW-1:0] req_vp = '0;
  logic [15:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic intc_present = 1'b1, pwr_present = 1'b1;
  logic [63:0] self_base, cpu_gbase, intc_base, pwr_base;
  logic intc_en, pwr_en;
  logic [NVP*64-1:0] vp_vector;

  always #10 clk = ~clk;  // 50 MHz

  clu_ctrl_regs #(.NVP(NVP)) uut (
    .clk(clk), .rst(rst), .req_vp(req_vp), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .intc_present(intc_present),
    .pwr_present(pwr_present), .self_base(self_base), .cpu_gbase(cpu_gbase),
    .intc_base(intc_base), .intc_en(intc_en), .pwr_base(pwr_base), .pwr_en(pwr_en),
    .vp_vector(vp_vector)
  );

  int n_run = 0, n_fail = 0;

  // reference state
  logic [63:0] m_sel [NVP];
  logic [63:0] m_rb  [NVP];
  logic [63:0] m_self, m_intc, m_pwr;

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] sext(logic [63:0] v);
    return {{32{v[31]}}, v[31:0]};
  endfunction

  function automatic int core_idx(int vp, logic [15:0] a);
    return (a[15:13] == 3'd1) ? vp : int'(m_sel[vp]);
  endfunction

  function automatic logic [63:0] m_read(int vp, logic [15:0] a);
    int k;
    if (a[15:13] == 3'd0) begin
      case (a[12:0])
        13'h008: return m_self;
        13'h010: return 64'h800;
        13'h018: return m_intc;
        13'h020: return m_pwr;
        13'h028: return {63'd0, intc_present};
        13'h030: return {63'd0, pwr_present};
        13'h038: return 64'h0010_0000;
        default: return 64'd0;
      endcase
    end
    if (a[15:13] == 3'd1 || a[15:13] == 3'd2) begin
      k = core_idx(vp, a);
      case (a[12:0])
        13'h010: return 64'(NVP - 1);
        13'h018: return m_sel[k];
        13'h020: return m_rb[k];
        default: return 64'd0;
      endcase
    end
    return 64'd0;
  endfunction

  task automatic m_write(int vp, logic [15:0] a, logic [63:0] d);
    int k;
    if (a[15:13] == 3'd0) begin
      case (a[12:0])
        13'h008: m_self = d & 64'h0000_FFFF_FFFF_8000;
        13'h018: if (intc_present) m_intc = d & 64'h0000_FFFF_FFFE_0001;
        13'h020: if (pwr_present)  m_pwr  = d & 64'h0000_FFFF_FFFF_8001;
        default: ;
      endcase
    end else if (a[15:13] == 3'd1 || a[15:13] == 3'd2) begin
      k = core_idx(vp, a);
      if (a[12:0] == 13'h018 && d[15:0] < 16'(NVP)) m_sel[k] = 64'(d[15:0]);
      if (a[12:0] == 13'h020) m_rb[k] = d & 64'h0000_0000_FFFF_F000;
    end
  endtask

  task automatic wr(int vp, logic [15:0] a, logic [63:0] d);
    @(negedge clk);
    req_vp = VPW'(vp); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    m_write(vp, a, d);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int vp, logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    req_vp = VPW'(vp); bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(string tag, int vp, logic [15:0] a);
    logic [63:0] d;
    logic [63:0] e;
    e = m_read(vp, a);
    rd(vp, a, d);
    check(tag, d, e);
  endtask

  task automatic chk_outs(string tag);
    check({tag, " self_base"}, self_base, m_self);
    check({tag, " cpu_gbase"}, cpu_gbase, m_self >> 4);
    check({tag, " intc_base"}, intc_base, m_intc & 64'h0000_FFFF_FFFE_0000);
    check({tag, " intc_en"}, 64'(intc_en), 64'(m_intc[0]));
    check({tag, " pwr_base"}, pwr_base, m_pwr & 64'h0000_FFFF_FFFF_8000);
    check({tag, " pwr_en"}, 64'(pwr_en), 64'(m_pwr[0]));
    for (int i = 0; i < NVP; i++)
      check({tag, " vector"}, vp_vector[i*64 +: 64], sext(m_rb[i]));
  endtask

  logic [15:0] addr_pool [15] = '{16'h0000, 16'h0008, 16'h0010, 16'h0018, 16'h0020,
    16'h0028, 16'h0030, 16'h0038, 16'h2010, 16'h2018, 16'h2020, 16'h4010, 16'h4018,
    16'h4020, 16'h6018};

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NVP; i++) begin
      m_sel[i] = 0;
      m_rb[i]  = 64'hBFC0_0000;
    end
    m_self = 64'h1FBF_8000; m_intc = 0; m_pwr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk_outs("R1 reset");
    check("R1 reset vector VP2", vp_vector[128 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    for (int v = 0; v < NVP; v++) begin
      rd_chk("R1 reset selector", v, 16'h2018);
      rd_chk("R1 reset rbase", v, 16'h2020);
    end

    // R7 / R10 constant registers
    rd_chk("R7 global cfg", 1, 16'h0000);
    rd(0, 16'h2010, d); check("R7 local cfg", d, 64'd2);
    rd(2, 16'h4010, d); check("R7 other cfg", d, 64'd2);
    rd(0, 16'h0010, d); check("R10 revision", d, 64'h800);
    rd(0, 16'h0038, d); check("R10 l2 bypass", d, 64'h0010_0000);

    // R2 read returns value before a same-edge write
    @(negedge clk);
    req_vp = 0; bus_addr = 16'h0008; bus_wdata = 64'hFFFF_FFFF_FFFF_FFFF; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2 read before write", bus_rdata, 64'h1FBF_8000);
    m_write(0, 16'h0008, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_we = 1'b0;
    check("R11 self mask", self_base, 64'h0000_FFFF_FFFF_8000);
    check("R11 cpu_gbase", cpu_gbase, 64'h0000_0FFF_FFFF_F800);

    // R8 sub-window fields
    wr(0, 16'h0018, 64'hFFFF_1234_5678_FFFF);
    check("R8 intc base", intc_base, 64'h0000_1234_5678_0000);
    check("R8 intc en", 64'(intc_en), 64'd1);
    wr(1, 16'h0020, 64'h0000_00AB_CDEF_8000);
    check("R8 pwr base", pwr_base, 64'h0000_00AB_CDEF_8000);
    check("R8 pwr en", 64'(pwr_en), 64'd0);
    rd_chk("R8 intc readback", 0, 16'h0018);

    // R9 absent sub-windows
    rd(0, 16'h0028, d); check("R9 intc status present", d, 64'd1);
    intc_present = 1'b0; pwr_present = 1'b0;
    rd(0, 16'h0030, d); check("R9 pwr status absent", d, 64'd0);
    wr(0, 16'h0018, 64'h0);
    wr(0, 16'h0020, 64'h0000_0000_0001_8001);
    check("R9 intc kept", intc_base, 64'h0000_1234_5678_0000);
    check("R9 pwr kept", pwr_base, 64'h0000_00AB_CDEF_8000);
    intc_present = 1'b1; pwr_present = 1'b1;

    // R5 selector range
    wr(0, 16'h2018, 64'd3);
    rd(0, 16'h2018, d); check("R5 selector 3 rejected", d, 64'd0);
    wr(0, 16'h2018, 64'h1_0002);
    rd(0, 16'h2018, d); check("R5 masked selector accepted", d, 64'd2);
    wr(1, 16'h4018, 64'hFFFF);
    rd(2, 16'h2018, d); check("R5 other-view reject", d, 64'd0);

    // R4 alias: VP0 points at VP2
    wr(0, 16'h4020, 64'hFFFF_FFFF_8765_4321);
    check("R4 R6 vector VP2", vp_vector[128 +: 64], 64'hFFFF_FFFF_8765_4000);
    check("R4 vector VP0 untouched", vp_vector[0 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    rd(2, 16'h2020, d); check("R3 local rbase VP2", d, 64'h8765_4000);
    wr(0, 16'h4018, 64'd1);
    rd(2, 16'h2018, d); check("R4 other-view selector write", d, 64'd1);
    wr(1, 16'h2020, 64'h0000_0000_1234_5FFF);
    check("R6 positive vector VP1", vp_vector[64 +: 64], 64'h0000_0000_1234_5000);

    // R12 unmapped
    wr(1, 16'h6018, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1, 16'h2028, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1, 16'h0040, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_outs("R12 unmapped write");
    rd(0, 16'h0048, d); check("R12 unmapped read", d, 64'd0);
    rd(0, 16'hE020, d); check("R12 high block read", d, 64'd0);

    // random mix, R3 R4 R5 R6 R8 R11 cross-checked
    for (int n = 0; n < 400; n++) begin
      int vp;
      logic [15:0] a;
      logic [63:0] dat;
      vp = int'($urandom % NVP);
      a  = ($urandom % 8 == 0) ? 16'($urandom) : addr_pool[$urandom % 15];
      dat = {$urandom, $urandom};
      if ($urandom % 3 == 0) dat[63:16] = '0;
      if ($urandom % 2 == 0) wr(vp, a, dat);
      else rd_chk("R3 R4 random read", vp, a);
      if (n % 20 == 0) chk_outs("R6 R11 random outputs");
    end
    chk_outs("R6 R8 final outputs");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule